// File: doc/BRIEF.md
# Dual-Slot In-Order Dispatch Unit

This block sits between instruction decode and the two general issue queues of an out-of-order core. It holds up to two decoded instructions in a small in-order buffer of two slots, the older one in slot 0. Each cycle it sends as many as two micro-operations onward on two dispatch lanes. Every instruction names the issue queue it goes to. Every micro-operation it sends takes one completion-queue entry, and the lane carries the index of that entry. The lane's valid bit also stands for a request for one general-purpose rename and one condition rename.

Dispatch depends on the mix of instructions and on the free space reported by each issue queue and by the completion queue. The younger slot never passes the older one. A load or store with address update is cracked into two parts: a memory part, then an add part. Each part takes its own lane, completion entry and renames. A flush empties the buffer and holds back all dispatch and all fetch acceptance in its cycle. The buffer refills from a two-wide fetch offer in the same cycle that space opens.

Top module: `dual_dispatch`

## Requirements
- R1: At most two lanes are valid in a cycle, and lane 1 is valid only when lane 0 is valid.
- R2: Lane 0 always carries the oldest buffered instruction. With enough room, two plain instructions leave together in program order.
- R3: The number of valid lanes never exceeds `cq_free`. A plain slot-1 instruction dispatches only when `cq_free` is at least 2.
- R4: The lanes sent to one issue queue never exceed that queue's free count. Two plain instructions that target the same queue need a free count of at least 2 there.
- R5: An update-form instruction (`upd`=1) dispatches only from slot 0, and only when `cq_free` is at least 2 and its own queue has at least 2 free entries. It then fills both lanes: lane 0 has kind 1 (memory part) and lane 1 has kind 2 (add part). Both lanes carry the same queue and payload. No other instruction leaves in that cycle. Plain instructions have kind 0.
- R6: Completion tags count from 0 after reset. Lane 0 takes the current tail index and lane 1 the next index, and both wrap at `CQ_DEPTH`. The tail advances by the number of valid lanes.
- R7: While `flush` is high, no lane is valid and `fe_take` is 0. In the following cycle the buffer is empty.
- R8: `fe_take` equals the number of offered instructions that fit in the slots left free after this cycle's dispatch. Offers are taken in order, and `fe_vld1` counts only together with `fe_vld0`.
- R9: Under reset the buffer is empty and no lane is valid.
- R10: When slot 0 cannot dispatch, slot 1 does not dispatch either, even if its own resources are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empties the buffer and blocks dispatch this cycle |
| fe_vld0 | input | 1 | First offered instruction is valid |
| fe_q0 | input | 1 | Target issue queue of first offer (0 or 1) |
| fe_upd0 | input | 1 | First offer is an update-form memory operation |
| fe_pl0 | input | PL_W | Payload of first offer |
| fe_vld1 | input | 1 | Second offered instruction is valid |
| fe_q1 | input | 1 | Target issue queue of second offer |
| fe_upd1 | input | 1 | Second offer is update-form |
| fe_pl1 | input | PL_W | Payload of second offer |
| fe_take | output | 2 | Number of offers accepted this cycle |
| iq0_free | input | $clog2(IQ_DEPTH+1) | Free entries in issue queue 0 |
| iq1_free | input | $clog2(IQ_DEPTH+1) | Free entries in issue queue 1 |
| cq_free | input | $clog2(CQ_DEPTH+1) | Free completion-queue entries |
| dl0_vld | output | 1 | Lane 0 valid (also a rename request) |
| dl0_q | output | 1 | Lane 0 target issue queue |
| dl0_kind | output | 2 | Lane 0 kind: 0 plain, 1 memory part, 2 add part |
| dl0_pl | output | PL_W | Lane 0 payload |
| dl0_tag | output | $clog2(CQ_DEPTH) | Lane 0 completion entry index |
| dl1_vld | output | 1 | Lane 1 valid |
| dl1_q | output | 1 | Lane 1 target issue queue |
| dl1_kind | output | 2 | Lane 1 kind |
| dl1_pl | output | PL_W | Lane 1 payload |
| dl1_tag | output | $clog2(CQ_DEPTH) | Lane 1 completion entry index |

## Verification
The bound checker watches the lane-level invariants on every cycle: lane 1 is never valid without lane 0, the lanes never exceed the completion or per-queue free counts, a memory part is always paired with its add part, tags run in sequence, and flush stays quiet. Ordering between the slots cannot be seen from one cycle of lanes alone. Neither can the stall of slot 1 behind a blocked slot 0, nor the payload of each dispatched instruction. Only the bench's reference queue shows these, using directed scenarios (blocked slot 0, a single free completion entry, a shared queue with one free entry, cracking under tight space, flush) and a long randomized run that wraps the tags.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
    typedef enum logic [1:0] {
        UOP_PLAIN = 2'd0,
        UOP_MEM   = 2'd1,
        UOP_ADD   = 2'd2
    } uop_kind_e;
endpackage

// File: rtl/dsp_slotbuf.sv
// Two-slot in-order instruction buffer; slot a is always the older one.
module dsp_slotbuf #(
    parameter int PL_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic [1:0]      used,
    input  logic            fe_vld0,
    input  logic            fe_q0,
    input  logic            fe_upd0,
    input  logic [PL_W-1:0] fe_pl0,
    input  logic            fe_vld1,
    input  logic            fe_q1,
    input  logic            fe_upd1,
    input  logic [PL_W-1:0] fe_pl1,
    output logic [1:0]      fe_take,
    output logic            s0_vld,
    output logic            s0_q,
    output logic            s0_upd,
    output logic [PL_W-1:0] s0_pl,
    output logic            s1_vld,
    output logic            s1_q,
    output logic            s1_upd,
    output logic [PL_W-1:0] s1_pl
);
    typedef struct packed {
        logic            vld;
        logic            q;
        logic            upd;
        logic [PL_W-1:0] pl;
    } slot_t;

    typedef struct packed {
        slot_t a;
        slot_t b;
    } buf_t;

    buf_t  st_d, st_q;
    slot_t in0, in1;
    logic [1:0] take;

    always_comb begin
        in0 = '{vld: fe_vld0, q: fe_q0, upd: fe_upd0, pl: fe_pl0};
        in1 = '{vld: fe_vld0 & fe_vld1, q: fe_q1, upd: fe_upd1, pl: fe_pl1};
        st_d = st_q;
        take = 2'd0;
        case (used)
            2'd1: begin
                st_d.a = st_q.b;
                st_d.b = '0;
            end
            2'd2: begin
                st_d.a = '0;
                st_d.b = '0;
            end
            default: ;
        endcase
        if (flush) begin
            st_d = '0;
        end else if (!st_d.a.vld) begin
            if (in0.vld) begin
                st_d.a = in0;
                take   = 2'd1;
                if (in1.vld) begin
                    st_d.b = in1;
                    take   = 2'd2;
                end
            end
        end else if (!st_d.b.vld && in0.vld) begin
            st_d.b = in0;
            take   = 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fe_take = take;
    assign s0_vld  = st_q.a.vld;
    assign s0_q    = st_q.a.q;
    assign s0_upd  = st_q.a.upd;
    assign s0_pl   = st_q.a.pl;
    assign s1_vld  = st_q.b.vld;
    assign s1_q    = st_q.b.q;
    assign s1_upd  = st_q.b.upd;
    assign s1_pl   = st_q.b.pl;
endmodule

// File: rtl/dsp_gate.sv
// Decides which slots leave this cycle and whether slot 0 is cracked.
module dsp_gate #(
    parameter  int IQ_DEPTH = 8,
    parameter  int CQ_DEPTH = 14,
    localparam int IQ_CW    = $clog2(IQ_DEPTH + 1),
    localparam int CQ_CW    = $clog2(CQ_DEPTH + 1)
) (
    input  logic             flush,
    input  logic             s0_vld,
    input  logic             s0_q,
    input  logic             s0_upd,
    input  logic             s1_vld,
    input  logic             s1_q,
    input  logic             s1_upd,
    input  logic [IQ_CW-1:0] iq0_free,
    input  logic [IQ_CW-1:0] iq1_free,
    input  logic [CQ_CW-1:0] cq_free,
    output logic             go0,
    output logic             go1,
    output logic             crack
);
    logic [IQ_CW-1:0] room0, room1;
    int               need1;

    always_comb begin
        go0   = 1'b0;
        go1   = 1'b0;
        crack = 1'b0;
        room0 = s0_q ? iq1_free : iq0_free;
        room1 = s1_q ? iq1_free : iq0_free;
        need1 = (s1_q == s0_q) ? 2 : 1;
        if (!flush && s0_vld) begin
            if (s0_upd) begin
                if (int'(cq_free) >= 2 && int'(room0) >= 2) begin
                    go0   = 1'b1;
                    crack = 1'b1;
                end
            end else if (int'(cq_free) >= 1 && int'(room0) >= 1) begin
                go0 = 1'b1;
                if (s1_vld && !s1_upd && int'(cq_free) >= 2 && int'(room1) >= need1)
                    go1 = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dsp_cqtag.sv
// Completion-queue tail pointer; hands out consecutive entry indices.
module dsp_cqtag #(
    parameter  int CQ_DEPTH = 14,
    localparam int TW       = $clog2(CQ_DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    adv,
    output logic [TW-1:0] tag0,
    output logic [TW-1:0] tag1
);
    typedef struct packed {
        logic [TW-1:0] tail;
    } tag_st_t;

    tag_st_t st_d, st_q;

    function automatic logic [TW-1:0] bump(input logic [TW-1:0] v);
        return (int'(v) == CQ_DEPTH - 1) ? '0 : v + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        case (adv)
            2'd1:    st_d.tail = bump(st_q.tail);
            2'd2:    st_d.tail = bump(bump(st_q.tail));
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tag0 = st_q.tail;
    assign tag1 = bump(st_q.tail);
endmodule

// File: rtl/dual_dispatch.sv
module dual_dispatch #(
    parameter  int PL_W     = 8,
    parameter  int IQ_DEPTH = 8,
    parameter  int CQ_DEPTH = 14,
    localparam int IQ_CW    = $clog2(IQ_DEPTH + 1),
    localparam int CQ_CW    = $clog2(CQ_DEPTH + 1),
    localparam int TW       = $clog2(CQ_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             fe_vld0,
    input  logic             fe_q0,
    input  logic             fe_upd0,
    input  logic [PL_W-1:0]  fe_pl0,
    input  logic             fe_vld1,
    input  logic             fe_q1,
    input  logic             fe_upd1,
    input  logic [PL_W-1:0]  fe_pl1,
    output logic [1:0]       fe_take,
    input  logic [IQ_CW-1:0] iq0_free,
    input  logic [IQ_CW-1:0] iq1_free,
    input  logic [CQ_CW-1:0] cq_free,
    output logic             dl0_vld,
    output logic             dl0_q,
    output logic [1:0]       dl0_kind,
    output logic [PL_W-1:0]  dl0_pl,
    output logic [TW-1:0]    dl0_tag,
    output logic             dl1_vld,
    output logic             dl1_q,
    output logic [1:0]       dl1_kind,
    output logic [PL_W-1:0]  dl1_pl,
    output logic [TW-1:0]    dl1_tag
);
    import dsp_pkg::*;

    logic            s0_vld, s0_q, s0_upd, s1_vld, s1_q, s1_upd;
    logic [PL_W-1:0] s0_pl, s1_pl;
    logic            go0, go1, crack;
    logic [1:0]      used, lanes;
    logic [TW-1:0]   tag0, tag1;

    assign used  = {1'b0, go0} + {1'b0, go1};
    assign lanes = {1'b0, go0} + {1'b0, go1 | crack};

    dsp_slotbuf #(.PL_W(PL_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .flush(flush), .used(used),
        .fe_vld0(fe_vld0), .fe_q0(fe_q0), .fe_upd0(fe_upd0), .fe_pl0(fe_pl0),
        .fe_vld1(fe_vld1), .fe_q1(fe_q1), .fe_upd1(fe_upd1), .fe_pl1(fe_pl1),
        .fe_take(fe_take),
        .s0_vld(s0_vld), .s0_q(s0_q), .s0_upd(s0_upd), .s0_pl(s0_pl),
        .s1_vld(s1_vld), .s1_q(s1_q), .s1_upd(s1_upd), .s1_pl(s1_pl)
    );

    dsp_gate #(.IQ_DEPTH(IQ_DEPTH), .CQ_DEPTH(CQ_DEPTH)) u_gate (
        .flush(flush),
        .s0_vld(s0_vld), .s0_q(s0_q), .s0_upd(s0_upd),
        .s1_vld(s1_vld), .s1_q(s1_q), .s1_upd(s1_upd),
        .iq0_free(iq0_free), .iq1_free(iq1_free), .cq_free(cq_free),
        .go0(go0), .go1(go1), .crack(crack)
    );

    dsp_cqtag #(.CQ_DEPTH(CQ_DEPTH)) u_tag (
        .clk(clk), .rst_n(rst_n), .adv(lanes), .tag0(tag0), .tag1(tag1)
    );

    always_comb begin
        dl0_vld  = go0;
        dl0_q    = s0_q;
        dl0_kind = crack ? UOP_MEM : UOP_PLAIN;
        dl0_pl   = s0_pl;
        dl0_tag  = tag0;
        dl1_vld  = go1 | crack;
        dl1_q    = crack ? s0_q : s1_q;
        dl1_kind = crack ? UOP_ADD : UOP_PLAIN;
        dl1_pl   = crack ? s0_pl : s1_pl;
        dl1_tag  = tag1;
    end
endmodule

// File: rtl/dual_dispatch_chk.sv
module dual_dispatch_chk #(
    parameter  int PL_W     = 8,
    parameter  int IQ_DEPTH = 8,
    parameter  int CQ_DEPTH = 14,
    localparam int IQ_CW    = $clog2(IQ_DEPTH + 1),
    localparam int CQ_CW    = $clog2(CQ_DEPTH + 1),
    localparam int TW       = $clog2(CQ_DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic [1:0]       fe_take,
    input logic [IQ_CW-1:0] iq0_free,
    input logic [IQ_CW-1:0] iq1_free,
    input logic [CQ_CW-1:0] cq_free,
    input logic             dl0_vld,
    input logic             dl0_q,
    input logic [1:0]       dl0_kind,
    input logic [PL_W-1:0]  dl0_pl,
    input logic [TW-1:0]    dl0_tag,
    input logic             dl1_vld,
    input logic             dl1_q,
    input logic [1:0]       dl1_kind,
    input logic [PL_W-1:0]  dl1_pl,
    input logic [TW-1:0]    dl1_tag
);
    function automatic logic [TW-1:0] nxt(input logic [TW-1:0] v);
        return (int'(v) == CQ_DEPTH - 1) ? '0 : v + 1'b1;
    endfunction

    // R1
    lane_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dl1_vld |-> dl0_vld);

    // R3
    cq_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(dl0_vld) + int'(dl1_vld) <= int'(cq_free));

    // R4
    iq0_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(dl0_vld && !dl0_q) + int'(dl1_vld && !dl1_q) <= int'(iq0_free));

    // R4
    iq1_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(dl0_vld && dl0_q) + int'(dl1_vld && dl1_q) <= int'(iq1_free));

    // R5
    crack_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dl0_vld && dl0_kind == 2'd1) |->
            (dl1_vld && dl1_kind == 2'd2 && dl1_q == dl0_q && dl1_pl == dl0_pl));

    // R6
    tag_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dl0_vld && dl1_vld) |-> dl1_tag == nxt(dl0_tag));

    // R6
    tag_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dl0_vld) && !$past(dl1_vld) && dl0_vld) |-> dl0_tag == nxt($past(dl0_tag)));

    // R7
    flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!dl0_vld && !dl1_vld && fe_take == 2'd0));

    // R7
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !dl0_vld);
endmodule

bind dual_dispatch dual_dispatch_chk #(
    .PL_W(PL_W), .IQ_DEPTH(IQ_DEPTH), .CQ_DEPTH(CQ_DEPTH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .fe_take(fe_take),
    .iq0_free(iq0_free), .iq1_free(iq1_free), .cq_free(cq_free),
    .dl0_vld(dl0_vld), .dl0_q(dl0_q), .dl0_kind(dl0_kind), .dl0_pl(dl0_pl), .dl0_tag(dl0_tag),
    .dl1_vld(dl1_vld), .dl1_q(dl1_q), .dl1_kind(dl1_kind), .dl1_pl(dl1_pl), .dl1_tag(dl1_tag)
);

// File: tb/dual_dispatch_tb.sv
module dual_dispatch_tb;
    localparam int PL_W = 8;
    localparam int IQD  = 8;
    localparam int CQD  = 14;

    logic       clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
    logic       fe_vld0 = 0, fe_q0 = 0, fe_upd0 = 0, fe_vld1 = 0, fe_q1 = 0, fe_upd1 = 0;
    logic [7:0] fe_pl0 = 0, fe_pl1 = 0;
    logic [3:0] iq0_free = 4'd8, iq1_free = 4'd8, cq_free = 4'd14;
    logic [1:0] fe_take;
    logic       dl0_vld, dl0_q, dl1_vld, dl1_q;
    logic [1:0] dl0_kind, dl1_kind;
    logic [7:0] dl0_pl, dl1_pl;
    logic [3:0] dl0_tag, dl1_tag;

    dual_dispatch #(.PL_W(PL_W), .IQ_DEPTH(IQD), .CQ_DEPTH(CQD)) u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .fe_vld0(fe_vld0), .fe_q0(fe_q0), .fe_upd0(fe_upd0), .fe_pl0(fe_pl0),
        .fe_vld1(fe_vld1), .fe_q1(fe_q1), .fe_upd1(fe_upd1), .fe_pl1(fe_pl1),
        .fe_take(fe_take), .iq0_free(iq0_free), .iq1_free(iq1_free), .cq_free(cq_free),
        .dl0_vld(dl0_vld), .dl0_q(dl0_q), .dl0_kind(dl0_kind), .dl0_pl(dl0_pl), .dl0_tag(dl0_tag),
        .dl1_vld(dl1_vld), .dl1_q(dl1_q), .dl1_kind(dl1_kind), .dl1_pl(dl1_pl), .dl1_tag(dl1_tag)
    );

    always #4 clk = ~clk;

    int    errs = 0, checks = 0, tail = 0;
    int    mq[$];
    string cur_req = "R2";
    bit    done = 0;
    int    x0v, x0q, x0k, x0p, x1v, x1q, x1k, x1p, xtake, xused;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model();
        int a, qa, ra, b, qb, rb, need, rem, offered;
        x0v = 0; x0q = 0; x0k = 0; x0p = 0; x1v = 0; x1q = 0; x1k = 0; x1p = 0; xused = 0;
        if (!flush && mq.size() > 0) begin
            a  = mq[0];
            qa = (a >> 9) & 1;
            ra = qa ? int'(iq1_free) : int'(iq0_free);
            if (((a >> 8) & 1) == 1) begin
                if (int'(cq_free) >= 2 && ra >= 2) begin
                    x0v = 1; x0q = qa; x0k = 1; x0p = a & 255;
                    x1v = 1; x1q = qa; x1k = 2; x1p = a & 255; xused = 1;
                end
            end else if (int'(cq_free) >= 1 && ra >= 1) begin
                x0v = 1; x0q = qa; x0p = a & 255; xused = 1;
                if (mq.size() > 1) begin
                    b    = mq[1];
                    qb   = (b >> 9) & 1;
                    rb   = qb ? int'(iq1_free) : int'(iq0_free);
                    need = (qb == qa) ? 2 : 1;
                    if (((b >> 8) & 1) == 0 && int'(cq_free) >= 2 && rb >= need) begin
                        x1v = 1; x1q = qb; x1p = b & 255; xused = 2;
                    end
                end
            end
        end
        rem     = mq.size() - xused;
        offered = fe_vld0 ? (fe_vld1 ? 2 : 1) : 0;
        xtake   = flush ? 0 : ((2 - rem) < offered ? (2 - rem) : offered);
    endtask

    task automatic step();
        #2;
        model();
        chk(int'(dl0_vld) == x0v, cur_req, "lane0 valid", int'(dl0_vld), x0v);
        chk(int'(dl1_vld) == x1v, cur_req, "lane1 valid", int'(dl1_vld), x1v);
        if (x0v == 1) begin
            chk(int'(dl0_q) == x0q, "R2", "lane0 queue", int'(dl0_q), x0q);
            chk(int'(dl0_pl) == x0p, "R2", "lane0 payload", int'(dl0_pl), x0p);
            chk(int'(dl0_kind) == x0k, "R5", "lane0 kind", int'(dl0_kind), x0k);
            chk(int'(dl0_tag) == tail, "R6", "lane0 tag", int'(dl0_tag), tail);
        end
        if (x1v == 1) begin
            chk(int'(dl1_q) == x1q, "R2", "lane1 queue", int'(dl1_q), x1q);
            chk(int'(dl1_pl) == x1p, "R2", "lane1 payload", int'(dl1_pl), x1p);
            chk(int'(dl1_kind) == x1k, "R5", "lane1 kind", int'(dl1_kind), x1k);
            chk(int'(dl1_tag) == (tail + 1) % CQD, "R6", "lane1 tag", int'(dl1_tag), (tail + 1) % CQD);
        end
        chk(int'(fe_take) == xtake, flush ? "R7" : "R8", "fetch take", int'(fe_take), xtake);
        @(posedge clk);
        if (flush) mq.delete();
        else repeat (xused) void'(mq.pop_front());
        if (xtake >= 1) mq.push_back(int'({fe_q0, fe_upd0, fe_pl0}));
        if (xtake == 2) mq.push_back(int'({fe_q1, fe_upd1, fe_pl1}));
        tail = (tail + x0v + x1v) % CQD;
        @(negedge clk);
    endtask

    task automatic offer(input bit v0, input bit q0, input bit u0, input int p0,
                         input bit v1, input bit q1, input bit u1, input int p1);
        fe_vld0 = v0; fe_q0 = q0; fe_upd0 = u0; fe_pl0 = 8'(p0);
        fe_vld1 = v1; fe_q1 = q1; fe_upd1 = u1; fe_pl1 = 8'(p1);
    endtask

    task automatic room(input int a, input int b, input int c);
        iq0_free = 4'(a); iq1_free = 4'(b); cq_free = 4'(c);
    endtask

    task automatic drain();
        offer(0, 0, 0, 0, 0, 0, 0, 0);
        room(8, 8, 14);
        cur_req = "R2";
        repeat (3) step();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: nothing leaves under reset
        chk(dl0_vld == 1'b0, "R9", "lane0 valid in reset", int'(dl0_vld), 0);
        chk(dl1_vld == 1'b0, "R9", "lane1 valid in reset", int'(dl1_vld), 0);
        rst_n = 1'b1;
        // R9, R8: empty buffer after reset accepts two
        cur_req = "R9";
        offer(1, 0, 0, 8'h11, 1, 1, 0, 8'h12);
        step();
        // R2: both plain leave in order, tags 0 and 1
        cur_req = "R2";
        offer(0, 0, 0, 0, 0, 0, 0, 0);
        step();
        // R10: slot 0 queue full blocks slot 1
        offer(1, 0, 0, 8'h21, 1, 1, 0, 8'h22);
        step();
        offer(0, 0, 0, 0, 0, 0, 0, 0);
        room(0, 8, 14);
        cur_req = "R10";
        step();
        step();
        drain();
        // R3: one completion entry lets one leave; offer refills
        offer(1, 1, 0, 8'h31, 1, 0, 0, 8'h32);
        step();
        room(8, 8, 1);
        cur_req = "R3";
        offer(1, 0, 0, 8'h33, 1, 0, 0, 8'h34);
        step();
        offer(0, 0, 0, 0, 0, 0, 0, 0);
        step();
        drain();
        // R4: same queue with one free entry
        offer(1, 1, 0, 8'h41, 1, 1, 0, 8'h42);
        step();
        offer(0, 0, 0, 0, 0, 0, 0, 0);
        room(8, 1, 14);
        cur_req = "R4";
        step();
        step();
        drain();
        // R5: cracked update op needs two entries
        offer(1, 1, 1, 8'h55, 1, 0, 1, 8'h56);
        step();
        offer(0, 0, 0, 0, 0, 0, 0, 0);
        room(8, 8, 1);
        cur_req = "R5";
        step();
        room(8, 1, 14);
        step();
        room(8, 8, 2);
        step();
        step();
        // R5: plain slot 0 then update in slot 1
        offer(1, 0, 0, 8'h57, 1, 0, 1, 8'h58);
        room(8, 8, 14);
        step();
        offer(0, 0, 0, 0, 0, 0, 0, 0);
        step();
        step();
        drain();
        // R7: flush empties the buffer and takes nothing
        offer(1, 0, 0, 8'h71, 1, 1, 0, 8'h72);
        step();
        flush = 1'b1;
        cur_req = "R7";
        step();
        flush = 1'b0;
        offer(0, 0, 0, 0, 0, 0, 0, 0);
        step();
        // R1, R6: randomized run, tags wrap many times
        cur_req = "R1";
        for (int i = 0; i < 600; i++) begin
            offer($urandom_range(0, 3) != 0, 1'($urandom), 1'($urandom_range(0, 3) == 0), int'($urandom_range(0, 255)),
                  $urandom_range(0, 1) == 1, 1'($urandom), 1'($urandom_range(0, 3) == 0), int'($urandom_range(0, 255)));
            room(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), int'($urandom_range(0, 3)));
            flush = ($urandom_range(0, 29) == 0);
            step();
        end
        flush = 1'b0;
        drain();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule